// File: doc/BRIEF.md
# Serial Register-Access Slave with Idle-Clock Recovery

This block is the four-wire serial slave that sits in front of a register file. A host frames a transfer with an active-low select. It clocks command and data bytes in on one wire and reads result bytes back on another. Every received byte is handed to the register side as a parallel word with a one-cycle strobe. The register side supplies the next word to send back, and the block serialises it most significant bit first.

The serial clock, select and data-in pins are brought into the system-clock domain through two-flop synchronisers, and both serial-clock edges are found there. A watchdog counts system clocks while the interface is selected, and every detected serial-clock edge restarts it. If the serial clock stays quiet for 4096 system clocks, or 256 when the short-timeout input is high, the watchdog drops any half-received byte and re-arms the shifter. A host that ties select low for good can therefore regain byte alignment by pausing the clock.

The control is a three-state machine. SEL_IDLE means deselected: the output is not driven and the serial pins are ignored. SEL_ARMED means selected at a byte boundary. SEL_SHIFT means selected partway through a byte. The transitions are:
- Entering select (SEL_IDLE to SEL_ARMED) loads the transmit word.
- The first rising clock edge of a byte moves SEL_ARMED to SEL_SHIFT.
- The eighth rising edge returns SEL_SHIFT to SEL_ARMED.
- A watchdog expiry returns SEL_SHIFT to SEL_ARMED.
- Leaving select returns any state to SEL_IDLE.

Top module: `spi_idle_slave`

## Requirements
- R1: After reset, with select high, `miso_oe`, `rx_valid` and `link_reset` are all 0.
- R2: While `cs_n` is high, `miso_oe` is 0, and toggling `sclk` and `mosi` produces no `rx_valid`.
- R3: Data on `mosi` is sampled at rising `sclk` edges, most significant bit first. After the 8th rising edge of a byte, `rx_byte` holds the byte and `rx_valid` is high for one cycle.
- R4: `miso` presents bit 7 of the transmit word before the first rising edge, and after each falling edge it moves to the next lower bit. `tx_byte` is captured when select becomes active and again at the first falling edge after a byte boundary.
- R5: Raising `cs_n` mid-byte discards the partial byte. After reselect, the next 8 rising edges form a whole, correctly aligned byte, and `miso` restarts from the MSB of `tx_byte`.
- R6: With `cs_n` held low, consecutive bytes are framed on every 8th rising edge without any select edge.
- R7: With `short_timeout` at 0 and select active, 4096 system clocks without a serial-clock edge raise `link_reset` for one cycle. The partial byte is dropped and the transmit word reloads.
- R8: With `short_timeout` at 1, the same recovery happens after 256 idle system clocks.
- R9: An idle gap shorter than the limit (300 cycles with `short_timeout` at 0) leaves the byte in progress intact, and `link_reset` stays low.
- R10: `link_reset` is a single-cycle pulse and never coincides with `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_timeout | input | 1 | 1 selects the 256-cycle idle limit, 0 the 4096-cycle limit |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for `miso`; 0 means the pad floats |
| tx_byte | input | 8 | Word to be sent in the next byte |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| link_reset | output | 1 | One-cycle pulse when the idle watchdog resets the interface |

## Verification
A serial-pin change reaches the detector after three system clocks: two synchroniser flops and one edge register. Each result then needs at most one more register stage. So `rx_valid` follows the 8th rising edge by about four cycles, `miso` settles within four cycles of a falling edge, and `miso_oe` follows `cs_n` within three. The bench holds each serial-clock phase for eight system clocks and samples `miso` just before it drives the next rising edge. A monitor pops expected bytes from the scoreboard whenever `rx_valid` appears, so the strobe's exact cycle does not matter. Watchdog pulses are counted over windows that extend well past 256 or 4096 cycles, and also over a 300-cycle window that must stay silent.

// File: rtl/spi_idle_pkg.sv
package spi_idle_pkg;

    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_ARMED = 2'd1,
        SEL_SHIFT = 2'd2
    } sel_state_t;

    localparam int unsigned LONG_IDLE_CYCLES  = 4096;
    localparam int unsigned SHORT_IDLE_CYCLES = 256;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic sel_active,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_q
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_pipe  <= '1;
                    clk_pipe <= '0;
                    dat_pipe <= '0;
                end else begin
                    cs_pipe  <= cs_n;
                    clk_pipe <= sclk;
                    dat_pipe <= mosi;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_pipe  <= '1;
                    clk_pipe <= '0;
                    dat_pipe <= '0;
                end else begin
                    cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
                    clk_pipe <= {clk_pipe[STAGES-2:0], sclk};
                    dat_pipe <= {dat_pipe[STAGES-2:0], mosi};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_last <= 1'b0;
        else        clk_last <= clk_pipe[STAGES-1];
    end

    assign sel_active = ~cs_pipe[STAGES-1];
    assign sclk_rise  = clk_pipe[STAGES-1] & ~clk_last;
    assign sclk_fall  = ~clk_pipe[STAGES-1] & clk_last;
    assign mosi_q     = dat_pipe[STAGES-1];
endmodule

// File: rtl/spi_idle_timer.sv
module spi_idle_timer #(
    parameter int unsigned LONG_LIMIT  = 4096,
    parameter int unsigned SHORT_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic activity,
    input  logic use_short,
    output logic expire
);
    localparam int unsigned CW = $clog2(LONG_LIMIT);
    localparam logic [CW-1:0] LONG_END  = CW'(LONG_LIMIT - 1);
    localparam logic [CW-1:0] SHORT_END = CW'(SHORT_LIMIT - 1);

    logic [CW-1:0] count;
    logic [CW-1:0] end_val;

    assign end_val = use_short ? SHORT_END : LONG_END;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (!armed || activity) begin
                count <= '0;
            end else if (count >= end_val) begin
                count  <= '0;
                expire <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_idle_pkg::*;
#(
    parameter int unsigned FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_active,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               mosi_q,
    input  logic               idle_expire,
    input  logic [FRAME_W-1:0] tx_byte,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               rx_valid,
    output logic               miso,
    output logic               miso_oe
);
    localparam int unsigned BW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    sel_state_t         state, state_nx;
    logic [BW-1:0]      bit_cnt;
    logic [FRAME_W-1:0] rx_sh;
    logic [FRAME_W-1:0] tx_sh;
    logic               load_next;
    logic               last_rise;

    assign last_rise = sclk_rise && (bit_cnt == LAST_BIT);

    always_comb begin
        state_nx = state;
        unique case (state)
            SEL_IDLE:  if (sel_active) state_nx = SEL_ARMED;
            SEL_ARMED: begin
                if (!sel_active)     state_nx = SEL_IDLE;
                else if (sclk_rise)  state_nx = (FRAME_W == 1) ? SEL_ARMED : SEL_SHIFT;
            end
            SEL_SHIFT: begin
                if (!sel_active)      state_nx = SEL_IDLE;
                else if (idle_expire) state_nx = SEL_ARMED;
                else if (last_rise)   state_nx = SEL_ARMED;
            end
            default:                  state_nx = SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEL_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            load_next <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!sel_active) begin
                bit_cnt   <= '0;
                load_next <= 1'b0;
            end else if (state == SEL_IDLE) begin
                tx_sh     <= tx_byte;
                bit_cnt   <= '0;
                load_next <= 1'b0;
            end else if (idle_expire) begin
                tx_sh     <= tx_byte;
                bit_cnt   <= '0;
                load_next <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[FRAME_W-2:0], mosi_q};
                    if (last_rise) begin
                        rx_byte   <= {rx_sh[FRAME_W-2:0], mosi_q};
                        rx_valid  <= 1'b1;
                        bit_cnt   <= '0;
                        load_next <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_fall) begin
                    if (load_next) begin
                        tx_sh     <= tx_byte;
                        load_next <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    always_comb begin
        miso_oe = (state != SEL_IDLE);
        miso    = miso_oe ? tx_sh[FRAME_W-1] : 1'b0;
    end
endmodule

// File: rtl/spi_idle_slave.sv
module spi_idle_slave
    import spi_idle_pkg::*;
#(
    parameter int unsigned FRAME_W     = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LONG_LIMIT  = LONG_IDLE_CYCLES,
    parameter int unsigned SHORT_LIMIT = SHORT_IDLE_CYCLES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               short_timeout,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               mosi,
    output logic               miso,
    output logic               miso_oe,
    input  logic [FRAME_W-1:0] tx_byte,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               rx_valid,
    output logic               link_reset
);
    logic sel_active;
    logic sclk_rise;
    logic sclk_fall;
    logic mosi_q;
    logic idle_expire;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .mosi       (mosi),
        .sel_active (sel_active),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .mosi_q     (mosi_q)
    );

    spi_idle_timer #(.LONG_LIMIT(LONG_LIMIT), .SHORT_LIMIT(SHORT_LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (sel_active),
        .activity  (sclk_rise | sclk_fall),
        .use_short (short_timeout),
        .expire    (idle_expire)
    );

    spi_byte_engine #(.FRAME_W(FRAME_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_active  (sel_active),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .mosi_q      (mosi_q),
        .idle_expire (idle_expire),
        .tx_byte     (tx_byte),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .miso        (miso),
        .miso_oe     (miso_oe)
    );

    assign link_reset = idle_expire;
endmodule

// File: rtl/spi_idle_slave_chk.sv
module spi_idle_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso_oe,
    input logic rx_valid,
    input logic link_reset
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!miso_oe && !rx_valid && !link_reset));

    // R2
    desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

    // R2
    desel_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !rx_valid);

    // R3
    rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_reset |=> !link_reset);

    // R10
    reset_vs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_reset && rx_valid));
endmodule

bind spi_idle_slave spi_idle_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .miso_oe    (miso_oe),
    .rx_valid   (rx_valid),
    .link_reset (link_reset)
);

// File: tb/tb_spi_idle_slave.sv
`timescale 1ns/1ps
module tb_spi_idle_slave;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       short_timeout = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       link_reset;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   lr_cycles = 0;
    int   unexpected = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    spi_idle_slave dut (
        .clk(clk), .rst_n(rst_n), .short_timeout(short_timeout),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .link_reset(link_reset)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Scoreboard monitor: pops expected bytes on each strobe (R3, R6)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                unexpected++;
                n_checks++;
                n_fails++;
                $display("FAIL R2 unexpected rx_byte actual=%0h expected=none", rx_byte);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_byte == e, "R3 rx_byte", rx_byte, e);
            end
        end
        if (rst_n && link_reset) lr_cycles++;
    end

    // Drive one byte; optionally pause before bit index pause_bit (7..0)
    task automatic xfer(input logic [7:0] din, input logic [7:0] exp_tx,
                        input logic [7:0] nxt, input int pause_bit, input int pause_len,
                        input string req);
        exp_q.push_back(din);
        for (int i = 7; i >= 0; i--) begin
            if (i == pause_bit) wait_clk(pause_len);
            mosi = din[i];
            wait_clk(HP);
            check(miso_oe && (miso == exp_tx[i]), req, {miso_oe, miso}, {1'b1, exp_tx[i]});
            sclk = 1'b1;
            if (i == 7) tx_byte = nxt;
            wait_clk(HP);
            sclk = 1'b0;
        end
        wait_clk(HP);
    endtask

    task automatic partial(input logic [7:0] din, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = din[i];
            wait_clk(HP);
            sclk = 1'b1;
            wait_clk(HP);
            sclk = 1'b0;
        end
        wait_clk(HP);
    endtask

    task automatic select(input bit on);
        cs_n = ~on;
        wait_clk(HP);
    endtask

    initial begin
        int lr0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        check(!miso_oe && !rx_valid && !link_reset, "R1 reset outputs",
              {miso_oe, rx_valid, link_reset}, 0);

        // R2 deselected: toggles ignored, pad floats
        for (int i = 0; i < 8; i++) begin
            mosi = i[0];
            wait_clk(HP);
            check(!miso_oe, "R2 miso_oe while deselected", miso_oe, 0);
            sclk = 1'b1; wait_clk(HP); sclk = 1'b0;
        end
        wait_clk(HP);
        check(unexpected == 0, "R2 no strobe while deselected", unexpected, 0);

        // R3 R4 R6 two bytes back to back
        tx_byte = 8'hA5;
        select(1);
        xfer(8'h3C, 8'hA5, 8'h96, -1, 0, "R4 miso first byte");
        xfer(8'hC3, 8'h96, 8'h0F, -1, 0, "R6 miso second byte");
        xfer(8'h01, 8'h0F, 8'h00, -1, 0, "R6 miso third byte");
        select(0);
        check(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);

        // R5 abort mid-byte
        tx_byte = 8'h5A;
        select(1);
        partial(8'hFF, 5);
        select(0);
        check(!miso_oe, "R5 pad floats after abort", miso_oe, 0);
        tx_byte = 8'hE1;
        select(1);
        xfer(8'h81, 8'hE1, 8'h00, -1, 0, "R5 miso after reselect");
        select(0);
        check(exp_q.size() == 0, "R5 aligned byte after abort", exp_q.size(), 0);

        // R7 long idle recovery
        short_timeout = 1'b0;
        tx_byte = 8'h77;
        select(1);
        partial(8'hFF, 3);
        lr0 = lr_cycles;
        wait_clk(4200);
        check(lr_cycles - lr0 == 1, "R7 one reset pulse after 4096 idle", lr_cycles - lr0, 1);
        xfer(8'hD2, 8'h77, 8'h00, -1, 0, "R7 miso reloaded after idle reset");
        select(0);
        check(exp_q.size() == 0, "R7 byte aligned after idle reset", exp_q.size(), 0);

        // R8 short idle recovery
        short_timeout = 1'b1;
        tx_byte = 8'hB4;
        select(1);
        partial(8'h00, 2);
        lr0 = lr_cycles;
        wait_clk(300);
        check(lr_cycles - lr0 == 1, "R8 one reset pulse after 256 idle", lr_cycles - lr0, 1);
        xfer(8'h4B, 8'hB4, 8'h00, -1, 0, "R8 miso reloaded after short reset");
        select(0);
        short_timeout = 1'b0;
        check(exp_q.size() == 0, "R8 byte aligned after short reset", exp_q.size(), 0);

        // R9 sub-limit gap keeps byte intact
        tx_byte = 8'h69;
        select(1);
        lr0 = lr_cycles;
        xfer(8'hF0, 8'h69, 8'h00, 3, 300, "R9 miso across short gap");
        select(0);
        check(lr_cycles - lr0 == 0, "R9 no reset for short gap", lr_cycles - lr0, 0);
        check(exp_q.size() == 0, "R9 byte intact across gap", exp_q.size(), 0);

        wait_clk(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait_clk(150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule